// File: doc/BRIEF.md
# Four-Digit Decimal Seconds Counter with Seven-Segment Scan

This block keeps a running decimal count from 0 up to 9999 that steps once per second and wraps back to 0. The count is kept as a 14-bit binary number. A purely combinational shift-and-add-three network turns it into four BCD digits, so no divider circuit is needed. A rotating one-cold select register then shows the digits one at a time on a shared set of active-low segment lines. The scan is fast enough that all four digits appear lit together.

Two internal dividers are built from the system clock. One gives the one-second step (`TICK_DIV` cycles). The other gives the digit scan step (`SCAN_DIV` cycles, about 1 kHz per digit by default). Both are parameters, so a bench can shorten them. A count enable can freeze the value while the display keeps refreshing. Leading zeros are displayed and the decimal point stays dark. If the select register ever holds a pattern other than one of the four legal codes, every segment line is driven high (blank).

Top module: `dcnt_display`

## Requirements
- R1: A low `rst_n` sampled at a rising clock edge (synchronous reset) sets the count to 0, `bcd_digits` to 16'h0000, and `dig_sel_n` to 4'b1110.
- R2: The count never exceeds 9999. A step taken at 9999 gives 0.
- R3: While `count_en` stays high, the count goes up by exactly 1 once every `TICK_DIV` clock cycles. The step divider runs freely from reset, whatever the enable does.
- R4: `bcd_digits` holds the current count in decimal. Nibble i (bits 4i+3..4i) is digit i, with digit 0 the ones and digit 3 the thousands, and each nibble lies in 0..9.
- R5: While `count_en` is low, the count and `bcd_digits` do not change.
- R6: `dig_sel_n` is active low with exactly one bit low. Every `SCAN_DIV` cycles it rotates right by one place (bit 3 takes the old bit 0), so the sequence is 1110, 0111, 1011, 1101, 1110.
- R7: While bit i of `dig_sel_n` is low, `seg_n[6:0]` carries digit i in active-low form, with bit 0 = segment a through bit 6 = segment g. In hex the codes for digits 0..9 are 40, 79, 24, 30, 19, 12, 02, 78, 00, 10.
- R8: `seg_n[7]`, the decimal point, is high (off) on every digit. Leading zero digits are shown with the code for 0 rather than blanked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| count_en | input | 1 | When high, the count advances on each one-second step |
| seg_n | output | 8 | Active-low segment lines: [6:0] segments a..g, [7] decimal point |
| dig_sel_n | output | 4 | Active-low digit select; bit i low shows digit i |
| bcd_digits | output | 16 | Four BCD digits of the current count, ones in the low nibble |

## Verification
A wrong count or a bad conversion step shows on `bcd_digits` in the same cycle the count register updates. The bench compares every value from 0 through the wrap against a division-based conversion of its own expected count. A stuck or corrupted select register shows as a rotation out of sequence, or as a wrong spacing, at the next scan step. Segment values are checked against the selected digit on every cycle, so a digit routed to the wrong select line or an encoding fault is caught within one scan step of the digit appearing.

// File: rtl/dcnt_pkg.sv
package dcnt_pkg;

    localparam int DIGITS    = 4;
    localparam int NIB_W     = 4;
    localparam int BIN_W     = 14;
    localparam int SEG_W     = 8;
    localparam int MAX_COUNT = 9999;
    localparam int BCD_W     = DIGITS * NIB_W;

    typedef logic [NIB_W-1:0]               nibble_t;
    typedef logic [DIGITS-1:0][NIB_W-1:0]   bcd_word_t;
    typedef logic [BIN_W-1:0]               bin_count_t;

    // Active-low segment pattern, bit 0 = a ... bit 6 = g; non-decimal input blanks
    function automatic logic [6:0] seg_encode(input nibble_t d);
        logic [6:0] r;
        case (d)
            4'd0: r = 7'h40;
            4'd1: r = 7'h79;
            4'd2: r = 7'h24;
            4'd3: r = 7'h30;
            4'd4: r = 7'h19;
            4'd5: r = 7'h12;
            4'd6: r = 7'h02;
            4'd7: r = 7'h78;
            4'd8: r = 7'h00;
            4'd9: r = 7'h10;
            default: r = 7'h7F;
        endcase
        return r;
    endfunction

    // One correction step of the shift-and-add-three method
    function automatic nibble_t dabble_adj(input nibble_t n);
        return (n >= 4'd5) ? nibble_t'(n + 4'd3) : n;
    endfunction

endpackage

// File: rtl/dcnt_divider.sv
module dcnt_divider #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    logic [W-1:0] cnt;

    assign tick = (cnt == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n)     cnt <= '0;
        else if (tick)  cnt <= '0;
        else            cnt <= cnt + 1'b1;
    end

    // R3: a step pulse lasts one cycle and is never followed directly by another
    p_tick_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/dcnt_bin2bcd.sv
module dcnt_bin2bcd
    import dcnt_pkg::*;
#(
    parameter int IN_W   = BIN_W,
    parameter int N_DIG  = DIGITS
) (
    input  logic [IN_W-1:0]        bin,
    output logic [N_DIG*NIB_W-1:0] bcd
);
    localparam int SW = N_DIG * NIB_W + IN_W;

    logic [SW-1:0] scratch;

    // Correct each BCD nibble, then shift in the next binary bit
    always_comb begin
        scratch = '0;
        scratch[IN_W-1:0] = bin;
        for (int b = 0; b < IN_W; b++) begin
            for (int d = 0; d < N_DIG; d++) begin
                scratch[IN_W + NIB_W*d +: NIB_W] = dabble_adj(scratch[IN_W + NIB_W*d +: NIB_W]);
            end
            scratch = scratch << 1;
        end
        bcd = scratch[SW-1:IN_W];
    end

endmodule

// File: rtl/dcnt_scan.sv
module dcnt_scan
    import dcnt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  bcd_word_t        digits,
    output logic [SEG_W-1:0] seg_n,
    output logic [DIGITS-1:0] sel_n
);
    localparam logic [DIGITS-1:0] SEL_RESET = {{(DIGITS-1){1'b1}}, 1'b0};

    always_ff @(posedge clk) begin
        if (!rst_n)     sel_n <= SEL_RESET;
        else if (step)  sel_n <= {sel_n[0], sel_n[DIGITS-1:1]};
    end

    // Route the digit whose select is low; any illegal pattern blanks all lines
    always_comb begin
        seg_n = '1;
        for (int i = 0; i < DIGITS; i++) begin
            if (sel_n == ~(DIGITS'(1) << i))
                seg_n = {1'b1, seg_encode(digits[i])};
        end
    end

    // R6: exactly one digit enabled at a time
    p_sel_onecold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(sel_n) == DIGITS - 1);

    // R6: select only moves on a scan step
    p_sel_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(sel_n));

    // R8: decimal point dark while a legal digit is shown
    p_dp_dark_r8: assert property (@(posedge clk) disable iff (!rst_n)
        seg_n[SEG_W-1]);

endmodule

// File: rtl/dcnt_display.sv
module dcnt_display
    import dcnt_pkg::*;
#(
    parameter int TICK_DIV = 50_000_000,
    parameter int SCAN_DIV = 50_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              count_en,
    output logic [SEG_W-1:0]  seg_n,
    output logic [DIGITS-1:0] dig_sel_n,
    output logic [BCD_W-1:0]  bcd_digits
);
    localparam bin_count_t LAST_VAL = bin_count_t'(MAX_COUNT);

    logic       sec_tick;
    logic       scan_tick;
    logic       advance;
    bin_count_t count;
    bcd_word_t  digits;

    dcnt_divider #(.DIV(TICK_DIV)) u_sec_div (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (sec_tick)
    );

    dcnt_divider #(.DIV(SCAN_DIV)) u_scan_div (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (scan_tick)
    );

    assign advance = sec_tick & count_en;

    always_ff @(posedge clk) begin
        if (!rst_n)                          count <= '0;
        else if (advance && count == LAST_VAL) count <= '0;
        else if (advance)                    count <= count + 1'b1;
    end

    dcnt_bin2bcd #(.IN_W(BIN_W), .N_DIG(DIGITS)) u_conv (
        .bin(count),
        .bcd(bcd_digits)
    );

    assign digits = bcd_word_t'(bcd_digits);

    dcnt_scan u_scan (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (scan_tick),
        .digits(digits),
        .seg_n (seg_n),
        .sel_n (dig_sel_n)
    );

    // R2: count stays inside the decimal range
    p_count_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        count <= LAST_VAL);

    // R2: step from the top value lands on zero
    p_count_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && count == LAST_VAL) |=> (count == '0));

    // R5: disabled count does not move
    p_count_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !count_en |=> $stable(count));

    // R4: every converted nibble is a decimal digit
    for (genvar g = 0; g < DIGITS; g++) begin : g_digit_chk
        p_digit_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
            digits[g] <= nibble_t'(9));
    end

endmodule

// File: tb/dcnt_display_bench.sv
`timescale 1ns/1ps
module dcnt_display_bench;

    localparam int TICK_DIV = 3;
    localparam int SCAN_DIV = 5;
    localparam int WATCHDOG = 150_000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        count_en = 1'b0;
    logic [7:0]  seg_n;
    logic [3:0]  dig_sel_n;
    logic [15:0] bcd_digits;

    int checks = 0;
    int fails  = 0;

    logic [6:0] codes [10] = '{7'h40, 7'h79, 7'h24, 7'h30, 7'h19,
                                7'h12, 7'h02, 7'h78, 7'h00, 7'h10};

    // monitor state
    bit         mon_on = 1'b0;
    int         exp_val = 0;
    int         since_change = 0;
    bit         en_steady = 1'b0;
    int         since_rot = 0;
    bit         rot_valid = 1'b0;
    logic [3:0] last_sel = 4'b1110;
    int         wraps = 0;

    always #2.5 clk = ~clk;

    dcnt_display #(.TICK_DIV(TICK_DIV), .SCAN_DIV(SCAN_DIV)) u_dcnt_display (
        .clk       (clk),
        .rst_n     (rst_n),
        .count_en  (count_en),
        .seg_n     (seg_n),
        .dig_sel_n (dig_sel_n),
        .bcd_digits(bcd_digits)
    );

    function automatic logic [15:0] to_bcd(input int v);
        return {4'(v / 1000 % 10), 4'(v / 100 % 10), 4'(v / 10 % 10), 4'(v % 10)};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Continuous checker of count progression, scan order and segment routing
    always @(negedge clk) begin
        if (mon_on && rst_n) begin
            since_change++;
            since_rot++;
            if (!count_en) en_steady = 1'b0;
            if (bcd_digits != to_bcd(exp_val)) begin
                check(bcd_digits == to_bcd((exp_val + 1) % 10000), "R4",
                      "bcd after step", 32'(bcd_digits), 32'(to_bcd((exp_val + 1) % 10000)));
                if (en_steady)
                    check(since_change == TICK_DIV, "R3", "step spacing",
                          32'(since_change), 32'(TICK_DIV));
                if (exp_val == 9999) begin
                    check(bcd_digits == 16'h0000, "R2", "wrap to zero", 32'(bcd_digits), 32'h0);
                    wraps++;
                end
                exp_val = (exp_val + 1) % 10000;
                since_change = 0;
                en_steady = count_en;
            end
            if (dig_sel_n != last_sel) begin
                check(dig_sel_n == {last_sel[0], last_sel[3:1]}, "R6", "rotation order",
                      32'(dig_sel_n), 32'({last_sel[0], last_sel[3:1]}));
                if (rot_valid)
                    check(since_rot == SCAN_DIV, "R6", "scan spacing", 32'(since_rot), 32'(SCAN_DIV));
                rot_valid = 1'b1;
                since_rot = 0;
                last_sel = dig_sel_n;
            end
            for (int i = 0; i < 4; i++) begin
                if (dig_sel_n == ~(4'b0001 << i))
                    check(seg_n == {1'b1, codes[bcd_digits[4*i +: 4]]}, "R7", "segment routing",
                          32'(seg_n), 32'({1'b1, codes[bcd_digits[4*i +: 4]]}));
            end
        end
    end

    task automatic do_reset();
        mon_on = 1'b0;
        @(posedge clk); #1;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(bcd_digits == 16'h0000, "R1", "reset bcd", 32'(bcd_digits), 32'h0);
        check(dig_sel_n == 4'b1110, "R1", "reset select", 32'(dig_sel_n), 32'he);
        check(seg_n == 8'hC0, "R1", "reset segments", 32'(seg_n), 32'hC0);
        exp_val = 0; since_change = 0; en_steady = 1'b0;
        since_rot = 0; rot_valid = 1'b0; last_sel = 4'b1110;
        mon_on = 1'b1;
    endtask

    task automatic test_leading_zero();
        // R8: with a small value the thousands digit shows the zero code, dp dark
        int n = 0;
        while (dig_sel_n != 4'b0111 && n < 40) begin
            @(negedge clk);
            n++;
        end
        check(bcd_digits[15:12] == 4'd0, "R8", "thousands nibble zero", 32'(bcd_digits[15:12]), 32'h0);
        check(seg_n == 8'hC0, "R8", "leading zero shown", 32'(seg_n), 32'hC0);
    endtask

    task automatic test_hold();
        logic [15:0] snap;
        @(posedge clk); #1 count_en = 1'b0;
        @(negedge clk);
        snap = bcd_digits;
        repeat (5 * TICK_DIV) @(negedge clk);
        check(bcd_digits == snap, "R5", "hold while disabled", 32'(bcd_digits), 32'(snap));
        check(seg_n[7] == 1'b1, "R8", "decimal point dark", 32'(seg_n[7]), 32'h1);
        @(posedge clk); #1 count_en = 1'b1;
        repeat (4 * TICK_DIV) @(negedge clk);
        check(bcd_digits != snap, "R3", "resumes after enable", 32'(bcd_digits), 32'(snap));
    endtask

    task automatic test_full_range();
        int n = 0;
        @(posedge clk); #1 count_en = 1'b1;
        while (wraps == 0 && n < 40_000) begin
            @(negedge clk);
            n++;
        end
        check(wraps == 1, "R2", "wrap reached", 32'(wraps), 32'h1);
        repeat (10 * TICK_DIV) @(negedge clk);
        check(bcd_digits == to_bcd(exp_val), "R4", "value after wrap", 32'(bcd_digits), 32'(to_bcd(exp_val)));
    endtask

    task automatic test_midrun_reset();
        @(posedge clk); #1 count_en = 1'b1;
        repeat (20 * TICK_DIV) @(negedge clk);
        check(bcd_digits != 16'h0000, "R1", "running before reset", 32'(bcd_digits), 32'h0);
        do_reset();
    endtask

    initial begin
        do_reset();
        test_leading_zero();
        test_hold();
        test_midrun_reset();
        test_full_range();
        test_hold();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule